// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product into a 64-bit accumulator kept as a high 32-bit half and a low 32-bit half. There are two operations. The long operation uses the full 32-bit operands. The word operation uses only the low 16 bits of each operand. A saturation input changes how the sum is written back, and each operation saturates in its own way. In the long operation, the sign of the sum forces the upper bits of the high half. In the word operation, an overflow of the signed 32-bit range writes a flag value of one into the high half and a clamped value into the low half.

A start strobe launches an operation. The product is registered in a multiplier stage and added to the accumulator one clock later. A one-cycle done pulse marks the write. A start that arrives while an operation is in its multiplier stage is dropped. Software sets up the accumulator through a synchronous clear and a parallel load, and reads both halves at all times.

Top module: `sat_mac`

## Requirements
- R1: With `op_word` = 0 (long), both 32-bit operands are sign-extended and multiplied, and the product is added to the 64-bit value {`acc_hi`,`acc_lo`}. With `sat_en` = 0 the full 64-bit sum is written back.
- R2: With `op_word` = 1 (word), only bits 15:0 of each operand are sign-extended and multiplied. Bits 31:16 of the operands have no effect.
- R3: With `sat_en` = 0, a sum that leaves the 64-bit signed range wraps modulo 2^64 in both operations, with no other effect.
- R4: Long operation with `sat_en` = 1 and a negative 64-bit sum: bits 31:16 of the high half are set to ones. The remaining high bits and the low half take the sum.
- R5: Long operation with `sat_en` = 1 and a non-negative sum: the high half keeps only its bits 14:0, and bits 31:15 become zero. The low half takes the sum.
- R6: Word operation with `sat_en` = 1 and a sum below -2^31: the high half becomes 1 and the low half becomes 0x80000000.
- R7: Word operation with `sat_en` = 1 and a sum above 2^31-1: the high half becomes 1 and the low half becomes 0x7FFFFFFF.
- R8: Word operation with `sat_en` = 1 and a sum from -2^31 to 2^31-1 inclusive: the full 64-bit sum is written unchanged.
- R9: A start sampled at a clock edge writes the accumulator at the next edge. `done` is high for exactly the one cycle after that write.
- R10: A start sampled at the edge directly after an accepted start is ignored. The accumulator is updated only once, and only one done pulse occurs.
- R11: `acc_clr` sets both halves to zero at the next edge. It has priority over a load and over a pending write-back.
- R12: `acc_ld` (without clear) writes `ld_hi`/`ld_lo` at the next edge. It overrides a pending write-back, which is discarded, but `done` still pulses.
- R13: After reset, both accumulator halves and `done` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch an operation |
| op_word | input | 1 | 0 = long (32x32), 1 = word (16x16) |
| sat_en | input | 1 | Saturating write-back |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| acc_clr | input | 1 | Synchronous accumulator clear |
| acc_ld | input | 1 | Parallel accumulator load |
| ld_hi | input | 32 | Load value, high half |
| ld_lo | input | 32 | Load value, low half |
| acc_hi | output | 32 | Accumulator high half |
| acc_lo | output | 32 | Accumulator low half |
| done | output | 1 | One-cycle write-back pulse |

## Verification
Some properties are checked by assertions on every cycle:
- A clear leaves zero and a load leaves the loaded value.
- The accumulator holds when idle.
- `done` never lasts two cycles.
- No second operation enters the multiplier stage behind the first.
- After a saturating long write, the high half has a legal shape: either the upper ones or a zeroed top.
- After a saturating word write, the result lies in the 32-bit signed range or is a flagged clamp.

Other behaviour can only be shown by the bench's scenarios:
- Exact sums and sign extension.
- Whether the operand upper bits are ignored in the word operation.
- Wrap-around without saturation.
- The exact edges of the word saturation range.
- Which of clear, load and write-back wins when they coincide.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;

   typedef enum logic {
      OP_LONG = 1'b0,
      OP_WORD = 1'b1
   } mac_op_e;

endpackage

// File: rtl/sat_mac_mul.sv
module sat_mac_mul
   import sat_mac_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int HALF_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                accept,
   input  mac_op_e             op,
   input  logic                sat,
   input  logic [DATA_W-1:0]   a,
   input  logic [DATA_W-1:0]   b,
   output logic                stage_v,
   output mac_op_e             stage_op,
   output logic                stage_sat,
   output logic [2*DATA_W-1:0] stage_prod
);

   localparam int ACC_W = 2 * DATA_W;
   localparam int PAD_L = ACC_W - DATA_W;
   localparam int PAD_W = ACC_W - HALF_W;

   if (HALF_W < 2 || HALF_W > DATA_W) begin : g_bad_width
      $error("sat_mac_mul: HALF_W must lie in 2..DATA_W");
   end

   logic [DATA_W-1:0] opnd [2];
   logic [ACC_W-1:0]  ext  [2];
   logic [ACC_W-1:0]  prod;

   assign opnd[0] = a;
   assign opnd[1] = b;

   for (genvar g = 0; g < 2; g++) begin : g_ext
      always_comb begin
         if (op == OP_WORD)
            ext[g] = {{PAD_W{opnd[g][HALF_W-1]}}, opnd[g][HALF_W-1:0]};
         else
            ext[g] = {{PAD_L{opnd[g][DATA_W-1]}}, opnd[g]};
      end
   end

   assign prod = ACC_W'($signed(ext[0]) * $signed(ext[1]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_v    <= 1'b0;
         stage_op   <= OP_LONG;
         stage_sat  <= 1'b0;
         stage_prod <= '0;
      end else begin
         stage_v <= accept;
         if (accept) begin
            stage_op   <= op;
            stage_sat  <= sat;
            stage_prod <= prod;
         end
      end
   end

   // R10: never two operations back to back in the multiplier stage
   p_single_flight_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      stage_v |=> !stage_v);

endmodule

// File: rtl/sat_mac_sat.sv
module sat_mac_sat
   import sat_mac_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int HALF_W   = 16,
   parameter int SAT_FLAG = 1
) (
   input  mac_op_e             op,
   input  logic                sat,
   input  logic [2*DATA_W-1:0] acc,
   input  logic [2*DATA_W-1:0] prod,
   output logic [2*DATA_W-1:0] nxt
);

   localparam int ACC_W = 2 * DATA_W;
   localparam logic [DATA_W-1:0] NEG_OR  = {{(DATA_W-HALF_W){1'b1}}, {HALF_W{1'b0}}};
   localparam logic [DATA_W-1:0] POS_AND = {{(DATA_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
   localparam logic [ACC_W-1:0]  LIM_MIN = {{(DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
   localparam logic [ACC_W-1:0]  LIM_MAX = {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] FLAG_HI = DATA_W'(SAT_FLAG);
   localparam logic [DATA_W-1:0] CLAMP_N = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] CLAMP_P = {1'b0, {(DATA_W-1){1'b1}}};

   if (SAT_FLAG < 0) begin : g_bad_flag
      $error("sat_mac_sat: SAT_FLAG must be non-negative");
   end

   logic [ACC_W-1:0]  sum;
   logic [DATA_W-1:0] sum_hi;
   logic [DATA_W-1:0] sum_lo;
   logic              below;
   logic              above;

   assign sum    = acc + prod;
   assign sum_hi = sum[ACC_W-1:DATA_W];
   assign sum_lo = sum[DATA_W-1:0];
   assign below  = $signed(sum) < $signed(LIM_MIN);
   assign above  = $signed(sum) > $signed(LIM_MAX);

   always_comb begin
      nxt = sum;
      if (sat) begin
         if (op == OP_LONG) begin
            if (sum[ACC_W-1])
               nxt = {sum_hi | NEG_OR, sum_lo};
            else
               nxt = {sum_hi & POS_AND, sum_lo};
         end else begin
            if (below)
               nxt = {FLAG_HI, CLAMP_N};
            else if (above)
               nxt = {FLAG_HI, CLAMP_P};
         end
      end
   end

endmodule

// File: rtl/sat_mac.sv
module sat_mac
   import sat_mac_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int HALF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_word,
   input  logic              sat_en,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              acc_clr,
   input  logic              acc_ld,
   input  logic [DATA_W-1:0] ld_hi,
   input  logic [DATA_W-1:0] ld_lo,
   output logic [DATA_W-1:0] acc_hi,
   output logic [DATA_W-1:0] acc_lo,
   output logic              done
);

   localparam int ACC_W = 2 * DATA_W;

   if (DATA_W < 4) begin : g_bad_data
      $error("sat_mac: DATA_W must be at least 4");
   end

   logic             accept;
   logic             stage_v;
   mac_op_e          stage_op;
   logic             stage_sat;
   logic [ACC_W-1:0] stage_prod;
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_nxt;
   mac_op_e          op_in;

   assign op_in  = op_word ? OP_WORD : OP_LONG;
   assign accept = start && !stage_v;

   sat_mac_mul #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_mul (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .op         (op_in),
      .sat        (sat_en),
      .a          (opnd_a),
      .b          (opnd_b),
      .stage_v    (stage_v),
      .stage_op   (stage_op),
      .stage_sat  (stage_sat),
      .stage_prod (stage_prod)
   );

   sat_mac_sat #(.DATA_W(DATA_W), .HALF_W(HALF_W), .SAT_FLAG(1)) u_sat (
      .op   (stage_op),
      .sat  (stage_sat),
      .acc  (acc_q),
      .prod (stage_prod),
      .nxt  (acc_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= stage_v;
         if (acc_clr)
            acc_q <= '0;
         else if (acc_ld)
            acc_q <= {ld_hi, ld_lo};
         else if (stage_v)
            acc_q <= acc_nxt;
      end
   end

   assign acc_hi = acc_q[ACC_W-1:DATA_W];
   assign acc_lo = acc_q[DATA_W-1:0];

   p_clear_zero_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      acc_clr |=> (acc_hi == '0 && acc_lo == '0));

   p_load_value_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (acc_ld && !acc_clr) |=> ({acc_hi, acc_lo} == $past({ld_hi, ld_lo})));

   p_done_single_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_start_to_done_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (start && !stage_v) |=> ##1 done);

   p_idle_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (!stage_v && !acc_clr && !acc_ld) |=> $stable({acc_hi, acc_lo}));

   // R4 and R5: shape of the high half after a saturating long write
   p_long_shape_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (stage_v && stage_op == OP_LONG && stage_sat && !acc_clr && !acc_ld) |=>
      (acc_hi[DATA_W-1] ? (&acc_hi[DATA_W-1:HALF_W])
                        : (acc_hi[DATA_W-1:HALF_W-1] == '0)));

   // R6, R7, R8: in 32-bit range or a flagged clamp
   p_word_range_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (stage_v && stage_op == OP_WORD && stage_sat && !acc_clr && !acc_ld) |=>
      ((acc_hi == {DATA_W{acc_lo[DATA_W-1]}}) ||
       (acc_hi == DATA_W'(1) &&
        (acc_lo == {1'b1, {(DATA_W-1){1'b0}}} || acc_lo == {1'b0, {(DATA_W-1){1'b1}}}))));

endmodule

// File: tb/sat_mac_bench.sv
module sat_mac_bench;

   typedef struct packed {
      logic        wd;
      logic        sat;
      logic [31:0] ih;
      logic [31:0] il;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] eh;
      logic [31:0] el;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      // R1: 3 * -5
      '{1'b0, 1'b0, 32'h0, 32'h0, 32'h3, 32'hFFFFFFFB, 32'hFFFFFFFF, 32'hFFFFFFF1, 4'd1},
      // R1: 2^16 * 2^16 plus existing low
      '{1'b0, 1'b0, 32'h0, 32'h10, 32'h00010000, 32'h00010000, 32'h1, 32'h10, 4'd1},
      // R1: -2^31 * 2
      '{1'b0, 1'b0, 32'h0, 32'h0, 32'h80000000, 32'h2, 32'hFFFFFFFF, 32'h0, 4'd1},
      // R2: upper bits ignored, 3 * -2
      '{1'b1, 1'b0, 32'h0, 32'h0, 32'hABCD0003, 32'h1234FFFE, 32'hFFFFFFFF, 32'hFFFFFFFA, 4'd2},
      // R2: 0x8000 is negative in word mode
      '{1'b1, 1'b0, 32'h0, 32'h0, 32'h00008000, 32'h00000002, 32'hFFFFFFFF, 32'hFFFF0000, 4'd2},
      // R3: long wrap
      '{1'b0, 1'b0, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h1, 32'h1, 32'h80000000, 32'h0, 4'd3},
      // R3: word wrap
      '{1'b1, 1'b0, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h1, 32'h1, 32'h80000000, 32'h0, 4'd3},
      // R4: negative sum forces upper ones
      '{1'b0, 1'b1, 32'h80001234, 32'h0, 32'h0, 32'h0, 32'hFFFF1234, 32'h0, 4'd4},
      // R5: non-negative sum keeps low 15 bits
      '{1'b0, 1'b1, 32'h12345678, 32'h9, 32'h2, 32'h3, 32'h00005678, 32'hF, 4'd5},
      // R5: -2^31 * -2^31 = 2^62
      '{1'b0, 1'b1, 32'h0, 32'h0, 32'h80000000, 32'h80000000, 32'h0, 32'h0, 4'd5},
      // R6: one below -2^31
      '{1'b1, 1'b1, 32'hFFFFFFFF, 32'h80000000, 32'h1, 32'hFFFF, 32'h1, 32'h80000000, 4'd6},
      // R6: far negative
      '{1'b1, 1'b1, 32'h80000000, 32'h0, 32'h0, 32'h0, 32'h1, 32'h80000000, 4'd6},
      // R7: one above 2^31-1
      '{1'b1, 1'b1, 32'h0, 32'h7FFFFFFF, 32'h1, 32'h1, 32'h1, 32'h7FFFFFFF, 4'd7},
      // R8: -16 + 20
      '{1'b1, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFF0, 32'h4, 32'h5, 32'h0, 32'h4, 4'd8},
      // R8: exactly 2^31-1
      '{1'b1, 1'b1, 32'h0, 32'h7FFFFFFE, 32'h1, 32'h1, 32'h0, 32'h7FFFFFFF, 4'd8},
      // R8: exactly -2^31
      '{1'b1, 1'b1, 32'hFFFFFFFF, 32'h80000001, 32'h1, 32'hFFFF, 32'hFFFFFFFF, 32'h80000000, 4'd8}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        op_word = 1'b0;
   logic        sat_en = 1'b0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic        acc_clr = 1'b0;
   logic        acc_ld = 1'b0;
   logic [31:0] ld_hi = '0;
   logic [31:0] ld_lo = '0;
   logic [31:0] acc_hi;
   logic [31:0] acc_lo;
   logic        done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   sat_mac u_sat_mac (
      .clk(clk), .rst_n(rst_n), .start(start), .op_word(op_word), .sat_en(sat_en),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_clr(acc_clr), .acc_ld(acc_ld),
      .ld_hi(ld_hi), .ld_lo(ld_lo), .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic load_acc(input logic [31:0] h, input logic [31:0] l);
      @(negedge clk);
      acc_ld = 1'b1; ld_hi = h; ld_lo = l;
      @(negedge clk);
      acc_ld = 1'b0;
   endtask

   task automatic launch(input logic w, input logic s, input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      start = 1'b1; op_word = w; sat_en = s; opnd_a = a; opnd_b = b;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL R9 watchdog actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R13: reset state
      chk("R13", {acc_hi, acc_lo}, 64'h0);
      chk("R13", {63'h0, done}, 64'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         load_acc(VEC[i].ih, VEC[i].il);
         launch(VEC[i].wd, VEC[i].sat, VEC[i].a, VEC[i].b);
         // multiplier stage holds the product; accumulator not yet written
         chk($sformatf("R9 vec%0d pre", i), {acc_hi, acc_lo}, {VEC[i].ih, VEC[i].il});
         @(negedge clk);
         chk($sformatf("R%0d vec%0d", VEC[i].req, i), {acc_hi, acc_lo}, {VEC[i].eh, VEC[i].el});
         chk($sformatf("R9 vec%0d done", i), {63'h0, done}, 64'h1);
         @(negedge clk);
         chk($sformatf("R9 vec%0d done low", i), {63'h0, done}, 64'h0);
      end

      // R10: start held for two cycles accumulates once
      load_acc(32'h0, 32'h0);
      @(negedge clk);
      start = 1'b1; op_word = 1'b0; sat_en = 1'b0; opnd_a = 32'h2; opnd_b = 32'h3;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      chk("R10 first write", {acc_hi, acc_lo}, 64'h6);
      chk("R10 done", {63'h0, done}, 64'h1);
      @(negedge clk);
      chk("R10 no second write", {acc_hi, acc_lo}, 64'h6);
      chk("R10 single pulse", {63'h0, done}, 64'h0);
      @(negedge clk);
      chk("R10 still once", {acc_hi, acc_lo}, 64'h6);

      // R1: back-to-back accumulation uses the updated accumulator
      launch(1'b0, 1'b0, 32'h4, 32'h5);
      @(negedge clk);
      chk("R1 accumulate", {acc_hi, acc_lo}, 64'h1A);

      // R12: load overrides pending write-back, done still pulses
      launch(1'b0, 1'b0, 32'h7, 32'h7);
      acc_ld = 1'b1; ld_hi = 32'h55; ld_lo = 32'hAA;
      @(negedge clk);
      acc_ld = 1'b0;
      chk("R12 load wins", {acc_hi, acc_lo}, {32'h55, 32'hAA});
      chk("R12 done", {63'h0, done}, 64'h1);

      // R11: clear beats load
      @(negedge clk);
      acc_clr = 1'b1; acc_ld = 1'b1; ld_hi = 32'h1; ld_lo = 32'h2;
      @(negedge clk);
      acc_clr = 1'b0; acc_ld = 1'b0;
      chk("R11 clear over load", {acc_hi, acc_lo}, 64'h0);

      // R11: clear beats write-back
      launch(1'b1, 1'b0, 32'h9, 32'h9);
      acc_clr = 1'b1;
      @(negedge clk);
      acc_clr = 1'b0;
      chk("R11 clear over write", {acc_hi, acc_lo}, 64'h0);

      // R13: reset in mid operation
      launch(1'b0, 1'b0, 32'h3, 32'h3);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R13 reset acc", {acc_hi, acc_lo}, 64'h0);
      chk("R13 reset done", {63'h0, done}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule